// File: doc/BRIEF.md
# Multi-Mode Sample Delay Store

This block is a fixed-length digital delay line for converter samples. One signed word arrives per strobe from an upstream converter interface. It moves through a 100-position store, and the word that leaves the far end is presented to a downstream converter interface. Taps at every tenth position expose the store contents at intermediate delays.

A 3-bit mode input is read only on an accepted strobe. It selects one of these operations:
- plain delay;
- hold, which freezes everything;
- pause, which zeroes the output and wipes the store;
- recirculation, where the store loops on itself and the input is ignored;
- recirculation with a frozen output;
- decimated tapped shifting, where one input is taken every tenth strobe and the whole store advances by one tap spacing.

Wiping the store takes a fixed number of system clocks. A busy output is high during the wipe, and strobes are refused while it is high.

Top module: `sample_delay_store`

## Requirements
- R1: After synchronous active-low reset, the output word, every tap and the busy flag are zero.
- R2: With mode code 0 (delay), each accepted strobe takes the input word into position 1, moves every position up by one, and loads the old position 100 word into the output register. A sample taken at strobe k therefore appears on the output at strobe k+100.
- R3: Tap n (n = 1..10, packed at bits [n*W-1:(n-1)*W] of the tap bus) always shows store position n*10, where position p holds the word that entered p-1 advances earlier.
- R4: With mode code 1 (hold), an accepted strobe leaves the store and the output unchanged.
- R5: With mode code 2 (pause), an accepted strobe forces the output to zero. The busy flag is then high for exactly 100 clocks starting in the next cycle, and all taps read zero once busy falls.
- R6: While busy is high, strobes are ignored whatever the mode and input. The output stays zero throughout.
- R7: With mode code 3 (recirculate), the input is ignored on each accepted strobe. Position 100 moves into position 1 and is also loaded into the output, so the contents repeat every 100 strobes.
- R8: With mode code 4 (recirculate with hold), the store rotates as in R7 but the output register keeps its value.
- R9: With mode code 5 (tapped shift), only the first strobe of a run and every tenth strobe after it act. On such a strobe, positions 1 to 10 all take the input word, every other position takes the word ten places below it, and the output takes the old position 100 word. The other strobes change nothing. Any accepted strobe in another mode restarts the count.
- R10: Without an accepted strobe (and outside a wipe), the mode and input are not looked at: the output and taps keep their values.
- R11: The unused mode codes 6 and 7 behave as hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | One-cycle advance request |
| mode | input | 3 | Operating mode code, read on accepted strobes |
| din | input | W (10) | Signed sample word from the input converter |
| dout | output | W (10) | Output word to the output converter |
| taps | output | W*10 (100) | Ten tap words, tap 1 in the low bits |
| busy | output | 1 | High while the store is being wiped |

## Verification
The bench builds the block with its default values: 10-bit words, 100 positions and a tap spacing of 10. At these values a full recirculation lap, a complete tapped-shift pass and a full 100-clock wipe all fit in a short run. A queue-based model is compared with the output, every tap and busy on each clock. The 8-bit width would only narrow the data path and is not built separately. The stimulus varies the gap between strobes and issues strobes during a wipe, so the deferred mode capture and the wipe lockout are exercised cycle by cycle.

// File: rtl/sdm_pkg.sv
// Shared mode codes and internal action encoding for the sample delay store.
// Assumes a 3-bit mode field; codes 6 and 7 are unused and decode as hold.
package sdm_pkg;
    localparam logic [2:0] MODE_DELAY       = 3'd0;
    localparam logic [2:0] MODE_HOLD        = 3'd1;
    localparam logic [2:0] MODE_PAUSE       = 3'd2;
    localparam logic [2:0] MODE_RECIRC      = 3'd3;
    localparam logic [2:0] MODE_RECIRC_HOLD = 3'd4;
    localparam logic [2:0] MODE_TAPSHIFT    = 3'd5;

    typedef enum logic [2:0] {
        ACT_IDLE   = 3'd0,
        ACT_FEED   = 3'd1,
        ACT_ROTATE = 3'd2,
        ACT_BLOCK  = 3'd3,
        ACT_ZERO   = 3'd4
    } act_e;
endpackage

// File: rtl/sdm_mode_ctrl.sv
// Mode controller: turns strobes and the mode code into one store action per
// clock. It also runs the wipe counter and the decimation phase for tapped shift.
// Assumes STEP >= 2 and a strobe at most one cycle wide per advance.
module sdm_mode_ctrl
    import sdm_pkg::*;
#(
    parameter int DEPTH = 100,
    parameter int STEP  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic [2:0] mode,
    output act_e       act,
    output logic       out_load,
    output logic       out_zero,
    output logic       busy
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PH_W  = $clog2(STEP + 1);

    logic [CNT_W-1:0] clr_cnt;
    logic [PH_W-1:0]  phase;
    logic             accept;

    assign busy   = (clr_cnt != '0);
    assign accept = strobe && !busy;

    // Decode the accepted strobe (or an ongoing wipe) into a store action.
    always_comb begin
        act      = ACT_IDLE;
        out_load = 1'b0;
        out_zero = 1'b0;
        if (busy) begin
            act = ACT_ZERO;
        end else if (accept) begin
            case (mode)
                MODE_DELAY: begin
                    act      = ACT_FEED;
                    out_load = 1'b1;
                end
                MODE_PAUSE: out_zero = 1'b1;
                MODE_RECIRC: begin
                    act      = ACT_ROTATE;
                    out_load = 1'b1;
                end
                MODE_RECIRC_HOLD: act = ACT_ROTATE;
                MODE_TAPSHIFT: begin
                    if (phase == '0) begin
                        act      = ACT_BLOCK;
                        out_load = 1'b1;
                    end
                end
                default: act = ACT_IDLE;
            endcase
        end
    end

    // Wipe counter: loaded on an accepted pause strobe, counts one per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clr_cnt <= '0;
        else if (busy)
            clr_cnt <= clr_cnt - 1'b1;
        else if (accept && mode == MODE_PAUSE)
            clr_cnt <= CNT_W'(DEPTH);
    end

    // Decimation phase: steps on tapped-shift strobes, restarts on any other mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (accept) begin
            if (mode == MODE_TAPSHIFT)
                phase <= (phase == PH_W'(STEP - 1)) ? '0 : phase + 1'b1;
            else
                phase <= '0;
        end
    end

    p_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase < PH_W'(STEP));
    p_clr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt <= CNT_W'(DEPTH));
    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (act == ACT_ZERO && !out_load && !out_zero));
endmodule

// File: rtl/sdm_shift_store.sv
// The DEPTH-word store. Each clock it applies one action: feed, rotate,
// block shift by STEP, shift-in zero, or idle. It exposes the last word and
// a tap every STEP positions. Assumes DEPTH is a multiple of STEP.
module sdm_shift_store
    import sdm_pkg::*;
#(
    parameter int W     = 10,
    parameter int DEPTH = 100,
    parameter int STEP  = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  act_e                        act,
    input  logic [W-1:0]                din,
    output logic [W-1:0]                last,
    output logic [(DEPTH/STEP)*W-1:0]   taps
);
    localparam int NTAPS = DEPTH / STEP;

    logic [W-1:0] pos [DEPTH];
    logic [W-1:0] nxt [DEPTH];

    // Next-state of every position for the requested action.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = pos[i];
        case (act)
            ACT_FEED: begin
                nxt[0] = din;
                for (int i = 1; i < DEPTH; i++) nxt[i] = pos[i-1];
            end
            ACT_ROTATE: begin
                nxt[0] = pos[DEPTH-1];
                for (int i = 1; i < DEPTH; i++) nxt[i] = pos[i-1];
            end
            ACT_ZERO: begin
                nxt[0] = '0;
                for (int i = 1; i < DEPTH; i++) nxt[i] = pos[i-1];
            end
            ACT_BLOCK: begin
                for (int i = 0; i < STEP; i++) nxt[i] = din;
                for (int i = STEP; i < DEPTH; i++) nxt[i] = pos[i-STEP];
            end
            default: ;
        endcase
    end

    // Register the whole store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            for (int i = 0; i < DEPTH; i++) pos[i] <= '0;
        else
            for (int i = 0; i < DEPTH; i++) pos[i] <= nxt[i];
    end

    assign last = pos[DEPTH-1];

    for (genvar n = 0; n < NTAPS; n++) begin : g_tap
        assign taps[n*W +: W] = pos[(n+1)*STEP-1];
    end

    p_idle_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IDLE) |=> $stable(taps));
endmodule

// File: rtl/sdm_out_reg.sv
// Output register toward the output converter: loads the departing word,
// forces zero on pause, otherwise keeps its value (hold behaviour).
module sdm_out_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         out_load,
    input  logic         out_zero,
    input  logic [W-1:0] last,
    output logic [W-1:0] dout
);
    // Update the presented word on load or zero request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (out_zero)
            dout <= '0;
        else if (out_load)
            dout <= last;
    end
endmodule

// File: rtl/sample_delay_store.sv
// Top of the multi-mode sample delay store: mode controller, word store and
// output register. Mode is read only on a strobe accepted while not busy.
module sample_delay_store
    import sdm_pkg::*;
#(
    parameter int W     = 10,
    parameter int DEPTH = 100,
    parameter int STEP  = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strobe,
    input  logic [2:0]                 mode,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic [(DEPTH/STEP)*W-1:0]  taps,
    output logic                       busy
);
    act_e         act;
    logic         out_load;
    logic         out_zero;
    logic [W-1:0] last;

    sdm_mode_ctrl #(.DEPTH(DEPTH), .STEP(STEP)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .mode(mode),
        .act(act), .out_load(out_load), .out_zero(out_zero), .busy(busy)
    );

    sdm_shift_store #(.W(W), .DEPTH(DEPTH), .STEP(STEP)) u_store (
        .clk(clk), .rst_n(rst_n), .act(act), .din(din),
        .last(last), .taps(taps)
    );

    sdm_out_reg #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .out_load(out_load), .out_zero(out_zero),
        .last(last), .dout(dout)
    );

    p_pause_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !busy && mode == MODE_PAUSE) |=> (dout == '0 && busy));
    p_wipe_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (taps == '0));
    p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (dout == '0));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !busy && (mode == MODE_HOLD || mode > MODE_TAPSHIFT))
        |=> ($stable(dout) && $stable(taps)));
    p_rhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !busy && mode == MODE_RECIRC_HOLD) |=> $stable(dout));
    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !busy) |=> ($stable(dout) && $stable(taps)));
endmodule

// File: tb/sample_delay_store_bench.sv
// Self-checking bench: a queue model of the store is stepped on every clock
// and compared with dout, all taps and busy a quarter period after each edge.
module sample_delay_store_bench;
    localparam int CLK_NS = 10;
    localparam int W      = 10;
    localparam int DEPTH  = 100;
    localparam int STEP   = 10;
    localparam int NT     = DEPTH / STEP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe = 1'b0;
    logic [2:0]        mode = 3'd0;
    logic [W-1:0]      din = '0;
    logic [W-1:0]      dout;
    logic [NT*W-1:0]   taps;
    logic              busy;

    sample_delay_store #(.W(W), .DEPTH(DEPTH), .STEP(STEP)) u_sample_delay_store (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .mode(mode), .din(din),
        .dout(dout), .taps(taps), .busy(busy)
    );

    always #(CLK_NS/2) clk = ~clk;

    logic [W-1:0] q[$];
    logic [W-1:0] m_dout;
    int           m_busy;
    int           m_phase;
    int           checks = 0;
    int           errors = 0;
    int           busy_cycles = 0;
    bit           done = 0;
    string        req = "R1";

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q.delete();
        for (int i = 0; i < DEPTH; i++) q.push_back('0);
        m_dout = '0; m_busy = 0; m_phase = 0;
    endtask

    // Reference behaviour, one step per clock.
    always @(posedge clk) begin
        logic [W-1:0] w;
        if (!rst_n) model_reset();
        else if (m_busy > 0) begin
            void'(q.pop_back()); q.push_front('0); m_busy--;
        end else if (strobe) begin
            case (mode)
                3'd0: begin m_dout = q.pop_back(); q.push_front(din); end
                3'd2: begin m_dout = '0; m_busy = DEPTH; end
                3'd3: begin w = q.pop_back(); q.push_front(w); m_dout = w; end
                3'd4: begin w = q.pop_back(); q.push_front(w); end
                3'd5: if (m_phase == 0) begin
                    m_dout = q[DEPTH-1];
                    repeat (STEP) void'(q.pop_back());
                    repeat (STEP) q.push_front(din);
                end
                default: ;
            endcase
            m_phase = (mode == 3'd5) ? (m_phase + 1) % STEP : 0;
        end
    end

    // Compare every cycle, away from the edge.
    always @(posedge clk) begin
        #(CLK_NS/4);
        if (!done && q.size() == DEPTH) begin
            chk(req, "dout", int'(dout), int'(m_dout));
            chk(req, "busy", int'(busy), int'(m_busy > 0));
            for (int n = 1; n <= NT; n++)
                chk((req == "R2") ? "R3" : req, $sformatf("tap%0d", n),
                    int'(taps[(n-1)*W +: W]), int'(q[n*STEP-1]));
            if (busy) busy_cycles++;
        end
    end

    task automatic pulses(input logic [2:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            mode = m; din = W'($urandom); strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            repeat (k % 3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset dout", int'(dout), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset taps", int'(taps == '0), 1);
        req = "R2";  pulses(3'd0, 250);
        req = "R4";  pulses(3'd1, 6);
        req = "R11"; pulses(3'd6, 3); pulses(3'd7, 3);
        req = "R7";  pulses(3'd3, 210);
        req = "R8";  pulses(3'd4, 30);
        req = "R9";  pulses(3'd5, 45);
        req = "R2";  pulses(3'd0, 7);
        req = "R9";  pulses(3'd5, 23);
        req = "R10";
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); mode = 3'(k % 8); din = W'($urandom);
        end
        req = "R5";
        busy_cycles = 0;
        pulses(3'd2, 1);
        req = "R6";
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); mode = 3'(k % 6); din = W'($urandom); strobe = 1'b1;
        end
        @(negedge clk); strobe = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R5", "busy length", busy_cycles, DEPTH);
        chk("R5", "taps after wipe", int'(taps == '0), 1);
        req = "R2";  pulses(3'd0, 120);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule